// File: doc/BRIEF.md
# Bus Cycle Termination Unit

This unit decides when each external bus cycle is finished and who finishes it. At the start of a cycle it picks one of three termination sources. The first is the ready line of an on-chip peripheral. The second is a wait-state down-counter that belongs to a chip-select region. The third is the shared active-low ready pin, driven by an off-chip device. The bus state machine receives a single one-clock completion strobe, whatever the source.

When the cycle is finished internally, the unit pulls its active-low local-access indicator low. It also enables the output buffer of the shared ready pin and drives that pin low, so external logic can watch the termination. When the cycle is finished externally, the buffer stays off and the pin is only sampled. A bus-active flag stays high for the whole cycle, including peripheral cycles, because the address is also placed on the external bus for on-chip targets. The pad is split into three signals: sampled input, driven value and output enable.

Top module: `bus_cycle_term`

## Requirements
- R1: Reset or the clock right after reset gives cyc_done=0, lba_n=1, rdy_oe=0 and bus_active=0.
- R2: A cycle started with periph_sel=1 finishes on periph_rdy. cyc_done is high in the clock after the edge that first samples periph_rdy=1.
- R3: With periph_sel=0, cs_hit=1 and cs_internal=1, the 5-bit cs_wait value N (0 to 31) is loaded on the start edge. cyc_done is high in the clock that follows N+2 edges after the start edge. N=0 gives two edges and N=31 gives 33.
- R4: With periph_sel=0 and cs_hit=0 or cs_internal=0, the cycle finishes on the pin. cyc_done is high in the clock after the edge that first samples rdy_in_n=0. Throughout such a cycle lba_n stays 1 and rdy_oe stays 0.
- R5: A cycle that finishes internally drives lba_n=0, rdy_oe=1 and rdy_out_n=0 in exactly the clock where cyc_done is 1, and at no other time.
- R6: A low rdy_in_n during an internally finished cycle has no effect on when that cycle finishes. A high periph_rdy during a pin-finished cycle has no effect either.
- R7: cyc_done lasts exactly one clock per started cycle. A cyc_start pulse that arrives while a cycle is in progress is ignored and produces no extra completion.
- R8: When periph_sel=1 and a wait-state region is also hit, the peripheral ready source takes priority.
- R9: bus_active is 1 from the clock after the start edge through the cyc_done clock, and 0 in the clock after that when no new cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse opening a bus cycle |
| periph_sel | input | 1 | Cycle targets an on-chip peripheral (sampled at start) |
| cs_hit | input | 1 | Cycle hits a chip-select region (sampled at start) |
| cs_internal | input | 1 | Hit region ends its cycles with the wait-state counter |
| cs_wait | input | 5 | Programmed wait-state count of the hit region |
| periph_rdy | input | 1 | Ready from the on-chip peripheral, active high |
| rdy_in_n | input | 1 | Sampled value of the shared ready pin, active low |
| rdy_out_n | output | 1 | Value driven onto the ready pin, low while driving |
| rdy_oe | output | 1 | Output enable of the ready pin buffer |
| lba_n | output | 1 | Local-access indicator, low when the unit terminates internally |
| cyc_done | output | 1 | One-clock cycle completion strobe |
| bus_active | output | 1 | A bus cycle is in progress; address is on the bus |

## Verification
The bench aims at the wait-count extremes 0 and 31. An off-by-one loader or counter would move the strobe by one clock there. It pulls the ready pin low throughout counter-terminated and peripheral cycles. A design that did not mask the pin would finish early and clash with its own driven ready. It raises periph_rdy during pin-terminated cycles, pulses cyc_start in the middle of a cycle, and selects a peripheral inside a wait-state region. A wrong source priority or a start decoder that is not gated would show up as an early or extra completion.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PERIPH = 2'd1,
        ST_COUNT  = 2'd2,
        ST_EXT    = 2'd3
    } term_state_e;

    typedef struct packed {
        logic periph_sel;
        logic cs_hit;
        logic cs_internal;
    } cyc_req_t;

    typedef struct packed {
        logic term_int;
        logic term_ext;
    } term_evt_t;

    // Peripheral access outranks the chip-select counter, which outranks the pin.
    function automatic term_state_e pick_source(cyc_req_t r);
        if (r.periph_sel)
            return ST_PERIPH;
        else if (r.cs_hit && r.cs_internal)
            return ST_COUNT;
        else
            return ST_EXT;
    endfunction

endpackage

// File: rtl/bt_wait_counter.sv
module bt_wait_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/bt_fsm.sv
module bt_fsm
    import bus_term_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  cyc_req_t    req,
    input  logic        periph_rdy,
    input  logic        ext_rdy_n,
    input  logic        cnt_zero,
    output term_state_e state,
    output logic        load,
    output logic        dec,
    output term_evt_t   evt
);
    term_state_e st_q, st_n;

    always_comb begin
        st_n         = st_q;
        load         = 1'b0;
        dec          = 1'b0;
        evt.term_int = 1'b0;
        evt.term_ext = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_n = pick_source(req);
                    load = 1'b1;
                end
            end
            ST_PERIPH: begin
                if (periph_rdy) begin
                    evt.term_int = 1'b1;
                    st_n         = ST_IDLE;
                end
            end
            ST_COUNT: begin
                if (cnt_zero) begin
                    evt.term_int = 1'b1;
                    st_n         = ST_IDLE;
                end else begin
                    dec = 1'b1;
                end
            end
            ST_EXT: begin
                if (!ext_rdy_n) begin
                    evt.term_ext = 1'b1;
                    st_n         = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_IDLE;
        else
            st_q <= st_n;
    end

    assign state = st_q;
endmodule

// File: rtl/bt_pin_stage.sv
module bt_pin_stage
    import bus_term_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  term_evt_t evt,
    output logic      drive_int,
    output logic      done
);
    logic drive_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            drive_q <= evt.term_int;
            done_q  <= evt.term_int | evt.term_ext;
        end
    end

    assign drive_int = drive_q;
    assign done      = done_q;
endmodule

// File: rtl/bus_cycle_term.sv
module bus_cycle_term
    import bus_term_pkg::*;
#(
    parameter int WS_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_start,
    input  logic            periph_sel,
    input  logic            cs_hit,
    input  logic            cs_internal,
    input  logic [WS_W-1:0] cs_wait,
    input  logic            periph_rdy,
    input  logic            rdy_in_n,
    output logic            rdy_out_n,
    output logic            rdy_oe,
    output logic            lba_n,
    output logic            cyc_done,
    output logic            bus_active
);
    cyc_req_t    req;
    term_state_e state;
    term_evt_t   evt;
    logic        load, dec, cnt_zero, drive_int, done;

    assign req.periph_sel  = periph_sel;
    assign req.cs_hit      = cs_hit;
    assign req.cs_internal = cs_internal;

    bt_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (cyc_start),
        .req        (req),
        .periph_rdy (periph_rdy),
        .ext_rdy_n  (rdy_in_n),
        .cnt_zero   (cnt_zero),
        .state      (state),
        .load       (load),
        .dec        (dec),
        .evt        (evt)
    );

    bt_wait_counter #(.CNT_W(WS_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (cs_wait),
        .dec      (dec),
        .zero     (cnt_zero)
    );

    bt_pin_stage i_pin (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .drive_int (drive_int),
        .done      (done)
    );

    assign rdy_oe     = drive_int;
    assign lba_n      = ~drive_int;
    assign rdy_out_n  = ~drive_int;
    assign cyc_done   = done;
    assign bus_active = (state != ST_IDLE) | done;
endmodule

// File: rtl/bus_cycle_term_chk.sv
module bus_cycle_term_chk (
    input logic clk,
    input logic rst,
    input logic cyc_start,
    input logic rdy_in_n,
    input logic rdy_out_n,
    input logic rdy_oe,
    input logic lba_n,
    input logic cyc_done,
    input logic bus_active
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cyc_done && lba_n && !rdy_oe && !bus_active));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> !cyc_done);

    // R5
    local_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !lba_n |-> (cyc_done && rdy_oe && !rdy_out_n));

    // R5
    oe_only_done_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_oe |-> cyc_done);

    // R4
    ext_done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_done && lba_n) |-> $past(!rdy_in_n));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_active && !cyc_done) |=> bus_active);

    // R9
    done_active_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |-> bus_active);
endmodule

bind bus_cycle_term bus_cycle_term_chk i_chk (.*);

// File: tb/test_bus_cycle_term.sv
module test_bus_cycle_term;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_start = 1'b0;
    logic       periph_sel = 1'b0;
    logic       cs_hit = 1'b0;
    logic       cs_internal = 1'b0;
    logic [4:0] cs_wait = '0;
    logic       periph_rdy = 1'b0;
    logic       rdy_in_n = 1'b1;
    logic       rdy_out_n, rdy_oe, lba_n, cyc_done, bus_active;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        bit    internal;
        string req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_cycle_term i_bus_cycle_term (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .periph_sel(periph_sel),
        .cs_hit(cs_hit), .cs_internal(cs_internal), .cs_wait(cs_wait),
        .periph_rdy(periph_rdy), .rdy_in_n(rdy_in_n), .rdy_out_n(rdy_out_n),
        .rdy_oe(rdy_oe), .lba_n(lba_n), .cyc_done(cyc_done), .bus_active(bus_active)
    );

    task automatic chk(bit ok, string r, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    // Monitor: compares every completion with the scoreboard head.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (cyc_done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7 extra completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.due, e.req, cyc, e.due);
                    chk(lba_n == !e.internal, "R5 lba_n", lba_n, !e.internal);
                    chk(rdy_oe == e.internal, "R5 rdy_oe", rdy_oe, e.internal);
                    if (e.internal) chk(rdy_out_n == 1'b0, "R5 rdy_out_n", rdy_out_n, 0);
                    chk(bus_active, "R9 active at done", bus_active, 1);
                end
            end else begin
                chk(lba_n && !rdy_oe, "R5 idle pin", {lba_n, rdy_oe}, 2);
            end
        end
    end

    // Driver. src: 0 peripheral, 1 wait counter, 2 ready pin.
    task automatic run(int src, int d, bit prio, bit noise, bit busy_start, string r);
        @(negedge clk);
        periph_sel  = (src == 0);
        cs_hit      = (src == 1) || prio;
        cs_internal = (src == 1) || prio;
        cs_wait     = prio ? 5'd0 : 5'(d);
        cyc_start   = 1'b1;
        sb.push_back('{cyc + 2 + d, src != 2, r});
        @(negedge clk);
        cyc_start = 1'b0; periph_sel = 1'b0; cs_hit = 1'b0; cs_internal = 1'b0;
        chk(bus_active, "R9 active after start", bus_active, 1);
        for (int i = 0; i < d; i++) begin
            cyc_start  = busy_start && (i == 0);
            periph_sel = busy_start && (i == 0);
            if (noise) begin
                if (src == 2) periph_rdy = 1'b1;  // R6
                else          rdy_in_n   = 1'b0;  // R6
            end
            @(negedge clk);
        end
        cyc_start = 1'b0; periph_sel = 1'b0; periph_rdy = 1'b0;
        if (src == 0) periph_rdy = 1'b1;
        if (src == 2) rdy_in_n = 1'b0;
        @(negedge clk);
        periph_rdy = 1'b0; rdy_in_n = 1'b1;
        @(negedge clk);
        chk(!bus_active, "R9 idle after done", bus_active, 0);
        chk(!cyc_done, "R7 one-clock strobe", cyc_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        chk(!cyc_done && lba_n && !rdy_oe && !bus_active, "R1 reset state",
            {cyc_done, lba_n, rdy_oe, bus_active}, 4'b0100);
        rst = 1'b0;
        @(negedge clk);
        chk(!cyc_done && lba_n && !rdy_oe && !bus_active, "R1 after reset",
            {cyc_done, lba_n, rdy_oe, bus_active}, 4'b0100);
        run(0, 0, 0, 0, 0, "R2 peripheral d0");
        run(0, 3, 0, 0, 0, "R2 peripheral d3");
        run(1, 0, 0, 0, 0, "R3 wait N0");
        run(1, 1, 0, 0, 0, "R3 wait N1");
        run(1, 31, 0, 0, 0, "R3 wait N31");
        run(1, 7, 0, 1, 0, "R6 pin low during wait");
        run(0, 2, 0, 1, 0, "R6 pin low during peripheral");
        run(2, 0, 0, 0, 0, "R4 pin d0");
        run(2, 4, 0, 1, 0, "R6 periph_rdy during pin cycle");
        run(1, 5, 0, 0, 1, "R7 start while busy");
        run(0, 4, 1, 0, 0, "R8 peripheral priority");
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R7 all completions seen", sb.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule